// File: doc/BRIEF.md
# Interrupt Mask Set/Clear Controller

This block holds the 32-bit interrupt enable mask of a host controller and turns a vector of pending interrupt events into a single processor interrupt line. Software never writes the mask directly. It writes ones through one of two word addresses on a simple valid/write register bus. One address turns the selected mask bits on and the other turns them off. A read at either address returns the present mask.

The top bit of the mask is a global gate. While it is low, the interrupt line stays low whatever the other bits hold. Each lower bit lets the event at the same position drive the line. Two of these bits pair with a vendor-specific event and a software-raised event. Six bit positions are reserved. They cannot be written and always read as zero.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A bus write (bus_valid=1, bus_write=1) to address 0x88 sets every writable mask bit that has a 1 in bus_wdata.
- R2: A bus write to address 0x8C clears every writable mask bit that has a 1 in bus_wdata.
- R3: Mask bits that have a 0 in the write data keep their value on a write to either address.
- R4: A bus read (bus_valid=1, bus_write=0) at 0x88 or 0x8C returns the current mask on bus_rdata in the same cycle. At any other time bus_rdata is zero.
- R5: Bit 28 and bits 14 to 10 are reserved. They always read as 0, and writes of 1 to them at either address have no effect.
- R6: Bit 31 is the master enable. While it is 0, irq_out is 0 in the following cycle whatever the events and the other mask bits hold.
- R7: For positions 30 down to 0, including 30 (vendor event) and 29 (software event), an event bit drives the interrupt only when the mask bit at the same position is 1.
- R8: irq_out is registered. After each rising edge it equals mask[31] AND the OR over bits 30:0 of (event_vec AND mask), taking the mask and events as they stood before that edge.
- R9: Reset clears the whole mask, including the master enable, and drives irq_out low.
- R10: A bus write to any address other than 0x88 or 0x8C leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Single-cycle bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data, one bit per mask position |
| bus_rdata | output | 32 | Read data, combinational |
| event_vec | input | 32 | Pending interrupt events, one per position |
| irq_out | output | 1 | Processor interrupt request |

## Verification
The assertions check on every cycle that the reserved positions stay zero, that a write to a foreign address leaves the mask stable, that a set or clear write takes effect on the next edge, and that a low master enable holds the interrupt line low. Other behaviour depends on sequences that only the bench's scenarios can show. These include per-position gating of the vendor and software events, events changing in the same cycle as a set or clear, repeated writes of ones to reserved bits, and the read data at both aliases and at a foreign address. The bench compares these against its own model of the mask.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
   localparam int unsigned MASK_W   = 32;
   localparam int unsigned ADDR_W   = 8;
   localparam int unsigned MASTER_POS = 31;
   localparam logic [MASK_W-1:0] RSVD_BITS = 32'h1000_7C00;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_SET   = 2'd1,
      ACC_CLEAR = 2'd2,
      ACC_READ  = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/irq_mask_decode.sv
module irq_mask_decode
   import irq_mask_pkg::*;
#(
   parameter int unsigned AW         = ADDR_W,
   parameter logic [AW-1:0] SET_ADDR = 'h88,
   parameter logic [AW-1:0] CLR_ADDR = 'h8C
)(
   input  logic          valid_i,
   input  logic          write_i,
   input  logic [AW-1:0] addr_i,
   output acc_kind_e     kind_o
);
   generate
      if (SET_ADDR == CLR_ADDR) begin : g_bad_alias
         $error("set and clear aliases must differ");
      end
   endgenerate

   logic hit_set, hit_clr;
   assign hit_set = (addr_i == SET_ADDR);
   assign hit_clr = (addr_i == CLR_ADDR);

   always_comb begin
      kind_o = ACC_NONE;
      if (valid_i) begin
         if (!write_i && (hit_set || hit_clr)) kind_o = ACC_READ;
         else if (write_i && hit_set)          kind_o = ACC_SET;
         else if (write_i && hit_clr)          kind_o = ACC_CLEAR;
      end
   end
endmodule

// File: rtl/irq_mask_store.sv
module irq_mask_store
   import irq_mask_pkg::*;
#(
   parameter int unsigned W         = MASK_W,
   parameter logic [W-1:0] RSVD     = RSVD_BITS
)(
   input  logic         clk,
   input  logic         rst_n,
   input  acc_kind_e    kind_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   localparam logic [W-1:0] WRITABLE = ~RSVD;

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         if (RSVD[b]) begin : g_rsvd
            assign mask_o[b] = 1'b0;
         end else begin : g_live
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                 q <= 1'b0;
               else if (kind_i == ACC_SET   && wdata_i[b]) q <= 1'b1;
               else if (kind_i == ACC_CLEAR && wdata_i[b]) q <= 1'b0;
            end
            assign mask_o[b] = q;
         end
      end
   endgenerate

   // R5: reserved positions never leave zero
   a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_o & RSVD) == '0);

   // R1: ones written at the set alias are present on the next edge
   a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
      kind_i == ACC_SET |=> ((mask_o & $past(wdata_i) & WRITABLE) == ($past(wdata_i) & WRITABLE)));

   // R2: ones written at the clear alias are gone on the next edge
   a_r2_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      kind_i == ACC_CLEAR |=> ((mask_o & $past(wdata_i)) == '0));

   // R10: no set or clear access means no mask change
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == ACC_NONE || kind_i == ACC_READ) |=> $stable(mask_o));
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate
   import irq_mask_pkg::*;
#(
   parameter int unsigned W      = MASK_W,
   parameter int unsigned MASTER = MASTER_POS
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] event_i,
   output logic         irq_o
);
   generate
      if (MASTER >= W) begin : g_bad_master
         $error("master enable position outside mask");
      end
   endgenerate

   logic [W-1:0] src_en;
   logic         any_src;

   always_comb begin
      src_en         = event_i & mask_i;
      src_en[MASTER] = 1'b0;
      any_src        = |src_en;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= mask_i[MASTER] & any_src;
   end

   // R6: master enable low holds the line low on the next cycle
   a_r6_master_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_i[MASTER] |=> !irq_o);

   // R7: no enabled event means no interrupt on the next cycle
   a_r7_no_enabled_src: assert property (@(posedge clk) disable iff (!rst_n)
      ((event_i & mask_i & ~(W'(1) << MASTER)) == '0) |=> !irq_o);
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
   import irq_mask_pkg::*;
#(
   parameter int unsigned      DATA_W   = MASK_W,
   parameter int unsigned      AW       = ADDR_W,
   parameter logic [AW-1:0]    SET_ADDR = 'h88,
   parameter logic [AW-1:0]    CLR_ADDR = 'h8C,
   parameter int unsigned      MASTER   = MASTER_POS,
   parameter logic [DATA_W-1:0] RSVD    = RSVD_BITS
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [AW-1:0]     bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] event_vec,
   output logic              irq_out
);
   generate
      if (RSVD[MASTER]) begin : g_bad_rsvd
         $error("master enable cannot be reserved");
      end
   endgenerate

   acc_kind_e         kind;
   logic [DATA_W-1:0] mask;

   irq_mask_decode #(.AW(AW), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
      .valid_i(bus_valid), .write_i(bus_write), .addr_i(bus_addr), .kind_o(kind));

   irq_mask_store #(.W(DATA_W), .RSVD(RSVD)) u_store (
      .clk(clk), .rst_n(rst_n), .kind_i(kind), .wdata_i(bus_wdata), .mask_o(mask));

   irq_mask_gate #(.W(DATA_W), .MASTER(MASTER)) u_gate (
      .clk(clk), .rst_n(rst_n), .mask_i(mask), .event_i(event_vec), .irq_o(irq_out));

   assign bus_rdata = (kind == ACC_READ) ? mask : '0;

   // R4: read data is zero outside a read hit
   a_r4_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |-> bus_rdata == '0);
endmodule

// File: tb/irq_mask_ctrl_tb.sv
module irq_mask_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, event_vec = '0;
   logic        irq_out;

   localparam logic [31:0] RSV = 32'h1000_7C00;

   int n_cmp = 0, n_bad = 0;
   logic [31:0] ref_mask = '0;
   bit   exp_q[$];
   string tag_q[$];
   bit   done = 0;

   always #10 clk = ~clk;

   irq_mask_ctrl u_dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .event_vec(event_vec), .irq_out(irq_out));

   task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // driver: one bus cycle, pushes the expected irq for after the edge
   task automatic cyc(string tag, bit v, bit w, logic [7:0] a, logic [31:0] d, logic [31:0] ev);
      bit exp_irq;
      @(negedge clk);
      bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; event_vec = ev;
      exp_irq = ref_mask[31] & (|(ev[30:0] & ref_mask[30:0]));
      #1;
      if (v && !w)
         check32({tag, " rdata"}, bus_rdata, (a == 8'h88 || a == 8'h8C) ? ref_mask : 32'h0);
      @(posedge clk);
      if (v && w && a == 8'h88) ref_mask = ref_mask | (d & ~RSV);
      if (v && w && a == 8'h8C) ref_mask = ref_mask & ~d;
      exp_q.push_back(exp_irq);
      tag_q.push_back(tag);
   endtask

   // monitor: compares irq after every edge driven by the driver
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         bit e; string t;
         e = exp_q.pop_front(); t = tag_q.pop_front();
         check32({t, " irq"}, {31'h0, irq_out}, {31'h0, e});
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: got hang expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check32("R9 irq in reset", {31'h0, irq_out}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      cyc("R9 mask after reset", 1, 0, 8'h88, 0, 32'hFFFF_FFFF);
      cyc("R7 enable bit0", 1, 1, 8'h88, 32'h0000_0001, 32'h1);
      cyc("R6 master off", 0, 0, 0, 0, 32'h1);
      cyc("R1 set master", 1, 1, 8'h88, 32'h8000_0000, 32'h1);
      cyc("R8 irq follows", 0, 0, 0, 0, 32'h1);
      cyc("R4 read set alias", 1, 0, 8'h88, 0, 32'h0);
      cyc("R4 read clear alias", 1, 0, 8'h8C, 0, 32'h0);
      cyc("R4 read foreign", 1, 0, 8'h90, 0, 32'h0);
      cyc("R5 set reserved", 1, 1, 8'h88, RSV, 32'h0);
      cyc("R5 set reserved again", 1, 1, 8'h88, RSV, 32'hFFFF_FFFF);
      cyc("R5 read reserved", 1, 0, 8'h8C, 0, RSV);
      cyc("R5 clear reserved", 1, 1, 8'h8C, RSV, RSV);
      cyc("R10 foreign write", 1, 1, 8'h90, 32'hFFFF_FFFF, 32'h0);
      cyc("R10 foreign write 84", 1, 1, 8'h84, 32'hFFFF_FFFF, 32'h0);
      cyc("R10 readback", 1, 0, 8'h88, 0, 32'h0);
      cyc("R7 vendor event blocked", 0, 0, 0, 0, 32'h4000_0000);
      cyc("R7 set vendor+soft", 1, 1, 8'h88, 32'h6000_0000, 32'h4000_0000);
      cyc("R7 vendor event", 0, 0, 0, 0, 32'h4000_0000);
      cyc("R7 soft event", 0, 0, 0, 0, 32'h2000_0000);
      cyc("R3 zero set", 1, 1, 8'h88, 0, 32'h2000_0000);
      cyc("R3 zero clear", 1, 1, 8'h8C, 0, 32'h2000_0000);
      cyc("R3 readback", 1, 0, 8'h8C, 0, 32'h2000_0000);
      cyc("R2 clear soft with event change", 1, 1, 8'h8C, 32'h2000_0000, 32'h2000_0001);
      cyc("R2 soft cleared", 0, 0, 0, 0, 32'h2000_0000);
      cyc("R6 clear master", 1, 1, 8'h8C, 32'h8000_0000, 32'h4000_0001);
      cyc("R6 master off events on", 0, 0, 0, 0, 32'h4000_0001);
      cyc("R6 master back on", 1, 1, 8'h88, 32'h8000_0000, 32'h4000_0001);
      cyc("R6 toggled on", 1, 0, 8'h88, 0, 32'h4000_0001);
      cyc("R1 set all", 1, 1, 8'h88, 32'hFFFF_FFFF, 32'h0000_0400);
      cyc("R5 reserved event", 0, 0, 0, 0, 32'h0000_0400);
      cyc("R1 readback all", 1, 0, 8'h88, 0, 32'h0002_0000);
      cyc("R2 clear all", 1, 1, 8'h8C, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
      cyc("R2 readback", 1, 0, 8'h8C, 0, 32'h7FFF_FFFF);
      cyc("R8 settle", 0, 0, 0, 0, 0);
      @(negedge clk); @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule